// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software by counting ticks of a slow time base and escalating in two steps when software fails to check in. The counter advances once for every clock cycle in which the low-speed tick enable is high. When it completes a full period without being serviced, the block emits a one-cycle non-maskable interrupt request so software gets a last chance to recover. If a second full period completes with still no service, the block raises a system reset request. That request stays high until the block itself is reset.

Software services the watchdog by writing a two-byte key through a small write port. A valid key restarts the count from zero and returns the escalation to its first stage. The counter cannot be stopped. The period is chosen by a 2-bit code. The code is followed until the first valid service after reset, after which it is frozen. With the default parameters and a 32.768 kHz tick, the four codes give 125 ms, 500 ms, 2 s and 8 s.

Top module: `esc_watchdog`

## Requirements
- R1: While `rst_n` is low at a clock edge, `nmi_pulse` and `rst_req` go low and the tick count and the escalation stage return to zero.
- R2: Period code c (0 to 3) selects 2^(PER_LOG2_BASE + PER_LOG2_STEP*c) ticks. The defaults 12 and 2 give 4096, 16384, 65536 and 262144 ticks. Only cycles with `tick_en` high advance the count, and no input stops it.
- R3: The edge that takes the last tick of a period without service raises `nmi_pulse` for exactly one clock cycle, on the first overflow since reset or since the last service.
- R4: The next overflow with no service in between raises `rst_req` instead of a second `nmi_pulse`. `rst_req` then stays high until `rst_n` is low.
- R5: A service is a write (`svc_we` high) of 0x5A followed by a write of 0xA5 as the next write. Cycles with `svc_we` low in between do not break the pair. A service sets the count to zero and returns the block to the first stage, so the next overflow gives `nmi_pulse` again.
- R6: A write of any other value breaks the pair, and 0xA5 with no 0x5A just before it has no effect. A repeated 0x5A keeps the pair armed.
- R7: `period_sel` is sampled in every cycle up to and including the cycle of the first valid service after reset. After that it is ignored.
- R8: When a service and the last tick of a period fall in the same cycle, the service wins. No `nmi_pulse` or `rst_req` results, and the next full period is counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Low-speed time base tick, one cycle per count |
| period_sel | input | 2 | Period code, 0 shortest to 3 longest |
| svc_we | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write data (key byte) |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The closing 0xA5 write of a service and the tick that completes a period can land in the same clock cycle. The bench provokes this by placing the two key writes on the last two ticks of a period. It then expects no interrupt in that cycle and an interrupt exactly one full period later, which shows that the count restarted from zero. A bound property also checks, in every run, that a cycle with a valid service is never followed by a new interrupt pulse or a change of the reset request.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the two-stage watchdog.
package wdt_pkg;
    localparam int          NUM_PERIODS = 4;
    localparam logic [7:0]  KEY_ARM     = 8'h5A;
    localparam logic [7:0]  KEY_FIRE    = 8'hA5;
    typedef logic [1:0] per_code_t;
endpackage

// File: rtl/wdt_key_check.sv
// Service key detector.
// Recognises a write of KEY_ARM followed, as the next write, by KEY_FIRE.
// Assumes: cycles without a write leave the armed state untouched.
module wdt_key_check
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       svc_ok
);
    logic armed_q;

    // Flag a completed key pair in the cycle of the second write.
    always_comb begin
        svc_ok = wr_en && (wr_data == KEY_FIRE) && armed_q;
    end

    // Every write re-arms on KEY_ARM and disarms on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= (wr_data == KEY_ARM);
        end
    end
endmodule

// File: rtl/wdt_period_lock.sv
// Period code register.
// Follows the select input until the first valid service, then freezes.
// Assumes: svc_ok is a single-cycle strobe from the key detector.
module wdt_period_lock
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  per_code_t sel_in,
    input  logic      svc_ok,
    output per_code_t per_q
);
    logic locked_q;

    // Track the select input while unlocked; lock on the first service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q    <= sel_in;
            locked_q <= 1'b0;
        end else if (!locked_q) begin
            per_q    <= sel_in;
            locked_q <= svc_ok;
        end
    end
endmodule

// File: rtl/wdt_counter.sv
// Free-running tick counter with a selectable power-of-two period.
// Raises ovf combinationally in the cycle whose tick completes a period.
// Assumes: clr (a service) takes priority over counting and overflow.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int PER_LOG2_BASE = 12,
    parameter int PER_LOG2_STEP = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  per_code_t per_code,
    input  logic      clr,
    output logic      ovf
);
    localparam int CNT_W = PER_LOG2_BASE + (NUM_PERIODS - 1) * PER_LOG2_STEP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val [NUM_PERIODS];
    logic             at_end;

    // One terminal count per period code.
    for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_last
        localparam int LOG2_LEN = PER_LOG2_BASE + g * PER_LOG2_STEP;
        assign last_val[g] = CNT_W'((64'(1) << LOG2_LEN) - 64'(1));
    end

    // Detect the tick that completes the selected period.
    always_comb begin
        at_end = (cnt_q >= last_val[per_code]);
        ovf    = tick && !clr && at_end;
    end

    // Advance on ticks, wrap at the terminal count, restart on service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_escalate.sv
// Two-stage escalation: first overflow gives an interrupt pulse,
// the next one without service gives a sticky reset request.
// Assumes: ovf and clr are never high together.
module wdt_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic clr,
    output logic nmi_q,
    output logic rst_q
);
    logic stage_q;

    // Update the stage flag, the one-cycle pulse and the sticky request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            nmi_q   <= 1'b0;
            rst_q   <= 1'b0;
        end else begin
            nmi_q <= ovf && !stage_q;
            if (clr) begin
                stage_q <= 1'b0;
            end else if (ovf) begin
                stage_q <= 1'b1;
            end
            if (ovf && stage_q) begin
                rst_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/esc_watchdog.sv
// Two-stage watchdog top level.
// Counts low-speed ticks, pulses an interrupt request on the first
// unserviced period and holds a reset request on the second.
// Assumes: tick_en is a one-cycle-per-tick enable in the clk domain.
module esc_watchdog
    import wdt_pkg::*;
#(
    parameter int PER_LOG2_BASE = 12,
    parameter int PER_LOG2_STEP = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] period_sel,
    input  logic       svc_we,
    input  logic [7:0] svc_data,
    output logic       nmi_pulse,
    output logic       rst_req
);
    logic      svc_ok;
    logic      ovf;
    per_code_t per_q;

    wdt_key_check u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (svc_we),
        .wr_data (svc_data),
        .svc_ok  (svc_ok)
    );

    wdt_period_lock u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_in (period_sel),
        .svc_ok (svc_ok),
        .per_q  (per_q)
    );

    wdt_counter #(
        .PER_LOG2_BASE (PER_LOG2_BASE),
        .PER_LOG2_STEP (PER_LOG2_STEP)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .per_code (per_q),
        .clr      (svc_ok),
        .ovf      (ovf)
    );

    wdt_escalate u_esc (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf),
        .clr   (svc_ok),
        .nmi_q (nmi_pulse),
        .rst_q (rst_req)
    );
endmodule

// File: rtl/wdt_checker.sv
// Property checker for esc_watchdog, attached by bind.
// Keeps its own record of interrupts and services seen since reset.
module wdt_checker
    import wdt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      svc_ok,
    input logic      ovf,
    input per_code_t per_q,
    input logic      nmi_pulse,
    input logic      rst_req
);
    logic seen_nmi;
    logic seen_svc;

    // Record an interrupt since the last service, and any service since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_nmi <= 1'b0;
            seen_svc <= 1'b0;
        end else begin
            if (svc_ok) seen_nmi <= 1'b0;
            else if (nmi_pulse) seen_nmi <= 1'b1;
            if (svc_ok) seen_svc <= 1'b1;
        end
    end

    AST_NMI_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) nmi_pulse |=> !nmi_pulse); // R3
    AST_NMI_FROM_OVF:  assert property (@(posedge clk) disable iff (!rst_n) nmi_pulse |-> $past(ovf)); // R3
    AST_RST_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req); // R4
    AST_RST_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_req) |-> seen_nmi); // R4
    AST_SVC_WINS:      assert property (@(posedge clk) disable iff (!rst_n) svc_ok |=> (!nmi_pulse && (rst_req == $past(rst_req)))); // R8
    AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) seen_svc |=> $stable(per_q)); // R7
endmodule

bind esc_watchdog wdt_checker u_wdt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_ok    (svc_ok),
    .ovf       (ovf),
    .per_q     (per_q),
    .nmi_pulse (nmi_pulse),
    .rst_req   (rst_req)
);

// File: tb/tb_esc_watchdog.sv
// Self-checking bench for esc_watchdog with short periods (8,16,32,64 ticks).
module tb_esc_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] period_sel = 2'd0;
    logic       svc_we = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       nmi_pulse;
    logic       rst_req;

    int n_chk = 0;
    int n_bad = 0;

    // Each row: period code, tick divider, edge of interrupt, edge of reset request.
    localparam int NV = 4;
    localparam int VT [NV][4] = '{
        '{0, 1,   8,  16},
        '{1, 2,  32,  64},
        '{2, 1,  32,  64},
        '{3, 3, 192, 384}
    };

    esc_watchdog #(
        .PER_LOG2_BASE (3),
        .PER_LOG2_STEP (1)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .period_sel (period_sel),
        .svc_we     (svc_we),
        .svc_data   (svc_data),
        .nmi_pulse  (nmi_pulse),
        .rst_req    (rst_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, return at the next falling edge.
    task automatic cyc(input bit t, input bit we, input logic [7:0] d);
        tick_en  = t;
        svc_we   = we;
        svc_data = d;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        svc_we  = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n      = 1'b0;
        period_sel = s;
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        do_reset(2'd0);
        chk("R1 nmi after reset", nmi_pulse, 1'b0);
        chk("R1 rst_req after reset", rst_req, 1'b0);

        // Table of periods and tick rates: interrupt then reset request.
        for (int v = 0; v < NV; v++) begin
            do_reset(2'(VT[v][0]));
            for (int e = 1; e <= VT[v][3]; e++) begin
                cyc(((e % VT[v][1]) == 0), 1'b0, 8'h00);
                if (e == VT[v][2] - 1) chk("R2 no nmi before period end", nmi_pulse, 1'b0);
                if (e == VT[v][2]) begin
                    chk("R3 nmi at first overflow", nmi_pulse, 1'b1);
                    chk("R3 no rst_req at first overflow", rst_req, 1'b0);
                end
                if (e == VT[v][2] + 1) chk("R3 nmi one cycle only", nmi_pulse, 1'b0);
                if (e == VT[v][3] - 1) chk("R4 rst_req before second overflow", rst_req, 1'b0);
                if (e == VT[v][3]) begin
                    chk("R4 rst_req at second overflow", rst_req, 1'b1);
                    chk("R4 no nmi at second overflow", nmi_pulse, 1'b0);
                end
            end
        end

        // R4: request holds, even across a service, until reset.
        ticks(20);
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'hA5);
        chk("R4 rst_req sticky", rst_req, 1'b1);
        do_reset(2'd0);
        chk("R1 rst_req cleared by reset", rst_req, 1'b0);

        // R8: service completes on the tick that ends the period.
        do_reset(2'd0);
        ticks(6);
        cyc(1'b1, 1'b1, 8'h5A);
        cyc(1'b1, 1'b1, 8'hA5);
        chk("R8 no nmi when service meets overflow", nmi_pulse, 1'b0);
        ticks(7);
        chk("R8 count restarted from zero", nmi_pulse, 1'b0);
        ticks(1);
        chk("R8 nmi one full period after service", nmi_pulse, 1'b1);

        // R5: service after an interrupt returns to the first stage.
        do_reset(2'd0);
        ticks(8);
        chk("R5 first interrupt", nmi_pulse, 1'b1);
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'hA5);
        ticks(7);
        chk("R5 no nmi before period", nmi_pulse, 1'b0);
        ticks(1);
        chk("R5 nmi again after service", nmi_pulse, 1'b1);
        chk("R5 no rst_req after service", rst_req, 1'b0);

        // R6: repeated arm byte still gives a valid service.
        do_reset(2'd0);
        ticks(4);
        cyc(1'b1, 1'b1, 8'h5A);
        cyc(1'b1, 1'b1, 8'h5A);
        cyc(1'b1, 1'b1, 8'hA5);
        ticks(7);
        chk("R6 repeated 0x5A then 0xA5 serviced", nmi_pulse, 1'b0);
        ticks(1);
        chk("R6 nmi one period after service", nmi_pulse, 1'b1);

        // R6: broken or lone key writes do not service.
        do_reset(2'd0);
        cyc(1'b1, 1'b1, 8'hA5);
        cyc(1'b1, 1'b1, 8'h5A);
        cyc(1'b1, 1'b1, 8'h33);
        cyc(1'b1, 1'b1, 8'hA5);
        ticks(3);
        chk("R6 no nmi before period", nmi_pulse, 1'b0);
        ticks(1);
        chk("R6 broken key ignored, nmi on time", nmi_pulse, 1'b1);

        // R7: code taken before service, frozen afterwards.
        do_reset(2'd0);
        period_sel = 2'd1;
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, 8'h5A);
        cyc(1'b0, 1'b1, 8'hA5);
        period_sel = 2'd0;
        ticks(8);
        chk("R7 late select ignored at 8 ticks", nmi_pulse, 1'b0);
        ticks(7);
        chk("R7 no nmi at 15 ticks", nmi_pulse, 1'b0);
        ticks(1);
        chk("R7 nmi at 16 ticks", nmi_pulse, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule